// File: doc/BRIEF.md
# Dual Wraparound Page Buffer

This block keeps two independent byte buffers, each as large as one page of a serial flash array (264 bytes by default). The host side reaches them one byte at a time through a serial-side port. A session opens with a start pulse that names a buffer and a starting byte offset, and it closes with an end pulse, which the surrounding logic raises when chip select is released. Within a session, each write or read strobe touches the byte under an internal pointer and then moves the pointer on. After the last byte the pointer returns to byte 0. Page sizes are not powers of two, so this wrap is computed and does not come from binary overflow.

A bulk port serves the array sequencer. One start pulse streams all bytes of one buffer, one byte per clock, beginning at offset 0. The stream either fills the buffer, as for a page-to-buffer transfer, or reads it out, as for a program or a compare. The sequencer locks a buffer while an array operation owns it. Serial writes to a locked buffer are dropped and serial reads from it return all ones. The other buffer stays fully usable.

Top module: `dual_page_buffer`

## Requirements
- R1: While rst_n is low at a clock edge, ser_rvalid, bulk_busy and bulk_rvalid are 0 after that edge.
- R2: A serial read strobe (ser_rd=1, ser_wr=0) in an open session gives ser_rvalid=1 with the addressed byte on ser_rdata in the cycle after the strobe edge; that byte is the one last written to that offset.
- R3: Each accepted serial strobe, read or write, moves the pointer to the next offset, so successive strobes reach consecutive bytes from the start offset.
- R4: After offset DEPTH-1 (263) the pointer continues at offset 0 of the same buffer.
- R5: A start offset of DEPTH or more is reduced by DEPTH (offset 300 selects byte 36).
- R6: Serial strobes outside a session, that is before the first ser_start or after ser_end, are ignored: no buffer byte changes and no ser_rvalid appears.
- R7: While lock[b] is 1, a serial write to buffer b is dropped, a serial read returns 8'hFF with ser_rvalid, and the pointer does not move.
- R8: Locking one buffer does not affect serial access to the other buffer.
- R9: A bulk_start while bulk_busy is 0 raises bulk_busy for exactly DEPTH cycles. bulk_idx counts 0 to DEPTH-1 in those cycles. In read mode (bulk_write=0) the byte at each index appears on bulk_rdata with bulk_rvalid one cycle later.
- R10: In write mode (bulk_write=1), the bulk_wdata present in each busy cycle is stored at that cycle's bulk_idx.
- R11: A bulk_start while bulk_busy is 1 is ignored, and the run in progress keeps its buffer, its direction and its length.
- R12: Serial writes to one buffer leave the bytes of the other buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock | input | NBUF | Per-buffer lock from the array sequencer |
| ser_start | input | 1 | Opens a serial session (pulse) |
| ser_sel | input | SW | Buffer chosen at ser_start |
| ser_offset | input | AW | Start byte offset captured at ser_start |
| ser_end | input | 1 | Closes the serial session (pulse) |
| ser_wr | input | 1 | Serial write strobe |
| ser_wdata | input | DW | Serial write byte |
| ser_rd | input | 1 | Serial read strobe |
| ser_rdata | output | DW | Serial read byte |
| ser_rvalid | output | 1 | ser_rdata valid |
| bulk_start | input | 1 | Starts a full-buffer bulk run (pulse) |
| bulk_sel | input | SW | Buffer for the bulk run |
| bulk_write | input | 1 | 1: fill buffer, 0: stream buffer out |
| bulk_wdata | input | DW | Fill byte for the current bulk index |
| bulk_busy | output | 1 | Bulk run in progress |
| bulk_idx | output | AW | Byte index of the current bulk cycle |
| bulk_rdata | output | DW | Streamed-out byte |
| bulk_rvalid | output | 1 | bulk_rdata valid |

## Verification
A serial read result is due in the cycle after its strobe edge. A bulk byte is due one cycle after the busy cycle that carried its index. bulk_busy rises one cycle after the start edge and stays high for 264 cycles. The driver tasks put each expected byte into a queue at the moment they issue the strobe or start the run. A monitor samples on the falling clock edge, so each byte is checked in its own cycle. The monitor pops the queue on every valid and fails any valid that arrives while the queue is empty. The busy length is counted cycle by cycle inside the bulk task.

// File: rtl/dpb_pkg.sv
// Shared helpers for the dual page buffer.
// Assumes page depth fits in 32 bits and that a raw offset is below 2*depth.
package dpb_pkg;

    typedef enum logic {
        BULK_DRAIN = 1'b0,
        BULK_FILL  = 1'b1
    } bulk_dir_e;

    // Next byte position with wrap at depth-1.
    function automatic int unsigned wrap_next(input int unsigned pos, input int unsigned depth);
        return (pos == depth - 1) ? 0 : pos + 1;
    endfunction

    // Fold an offset of depth or more back into range.
    function automatic int unsigned fold_offset(input int unsigned off, input int unsigned depth);
        return (off >= depth) ? off - depth : off;
    endfunction

endpackage

// File: rtl/dpb_ptr.sv
// Serial byte pointer: loads a folded start offset, steps with wrap at DEPTH-1.
// Assumes DEPTH <= 2**AW < 2*DEPTH so a single fold suffices.
module dpb_ptr #(
    parameter int DEPTH = 264,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    import dpb_pkg::*;

    // Pointer register: load has priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= AW'(fold_offset(32'(load_val), DEPTH));
        else if (step)
            ptr <= AW'(wrap_next(32'(ptr), DEPTH));
    end
endmodule

// File: rtl/dpb_bank.sv
// One page buffer: single write port, registered read port.
// Assumes callers keep addresses below DEPTH; contents are not reset.
module dpb_bank #(
    parameter int DEPTH = 264,
    parameter int DW    = 8,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Byte write.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Registered byte read.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/dpb_bulk.sv
// Bulk sequencer: on start (when idle) walks index 0..DEPTH-1, one per clock,
// latching buffer select and direction for the whole run.
module dpb_bulk #(
    parameter int DEPTH = 264,
    parameter int AW    = 9,
    parameter int SW    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SW-1:0]     sel,
    input  logic              write,
    output logic              busy,
    output logic [AW-1:0]     idx,
    output logic [SW-1:0]     sel_q,
    output dpb_pkg::bulk_dir_e dir_q
);
    import dpb_pkg::*;

    // Run control: accept start only when idle, stop after the last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx   <= '0;
            sel_q <= '0;
            dir_q <= BULK_DRAIN;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                idx   <= '0;
                sel_q <= sel;
                dir_q <= bulk_dir_e'(write);
            end
        end else if (idx == AW'(DEPTH - 1)) begin
            busy <= 1'b0;
            idx  <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/dual_page_buffer.sv
// Two page buffers with a serial byte port (wrapping pointer, per-buffer lock)
// and a bulk streaming port for the array sequencer.
// Assumes the sequencer locks a buffer before running bulk on it; bulk access
// wins a same-cycle conflict on a buffer.
module dual_page_buffer #(
    parameter int DEPTH = 264,
    parameter int DW    = 8,
    parameter int NBUF  = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NBUF-1:0] lock,
    input  logic          ser_start,
    input  logic [SW-1:0] ser_sel,
    input  logic [AW-1:0] ser_offset,
    input  logic          ser_end,
    input  logic          ser_wr,
    input  logic [DW-1:0] ser_wdata,
    input  logic          ser_rd,
    output logic [DW-1:0] ser_rdata,
    output logic          ser_rvalid,
    input  logic          bulk_start,
    input  logic [SW-1:0] bulk_sel,
    input  logic          bulk_write,
    input  logic [DW-1:0] bulk_wdata,
    output logic          bulk_busy,
    output logic [AW-1:0] bulk_idx,
    output logic [DW-1:0] bulk_rdata,
    output logic          bulk_rvalid
);
    import dpb_pkg::*;

    logic          ser_act;
    logic [SW-1:0] ser_buf_q;
    logic          ser_locked;
    logic          wr_go;
    logic          rd_go;
    logic [AW-1:0] ser_ptr;
    logic          rd_lock_q;
    logic [SW-1:0] rd_sel_q;
    logic [SW-1:0] bulk_sel_q;
    bulk_dir_e     bulk_dir_q;
    logic [SW-1:0] bulk_rsel_q;
    logic [DW-1:0] bank_rd [NBUF];

    // Session tracking: start opens (and wins), end closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_act   <= 1'b0;
            ser_buf_q <= '0;
        end else if (ser_start) begin
            ser_act   <= 1'b1;
            ser_buf_q <= ser_sel;
        end else if (ser_end) begin
            ser_act <= 1'b0;
        end
    end

    // Accepted strobes: write has precedence over read in one cycle.
    always_comb begin
        ser_locked = lock[ser_buf_q];
        wr_go      = ser_act && !ser_locked && ser_wr;
        rd_go      = ser_act && !ser_locked && ser_rd && !ser_wr;
    end

    dpb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ser_start),
        .load_val (ser_offset),
        .step     (wr_go || rd_go),
        .ptr      (ser_ptr)
    );

    dpb_bulk #(.DEPTH(DEPTH), .AW(AW), .SW(SW)) u_bulk (
        .clk   (clk),
        .rst_n (rst_n),
        .start (bulk_start),
        .sel   (bulk_sel),
        .write (bulk_write),
        .busy  (bulk_busy),
        .idx   (bulk_idx),
        .sel_q (bulk_sel_q),
        .dir_q (bulk_dir_q)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        logic          here;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;

        // Port steering: bulk owns the bank during its run.
        always_comb begin
            here = bulk_busy && (bulk_sel_q == SW'(g));
            we   = here ? (bulk_dir_q == BULK_FILL) : (wr_go && (ser_buf_q == SW'(g)));
            addr = here ? bulk_idx : ser_ptr;
            wd   = here ? bulk_wdata : ser_wdata;
        end

        dpb_bank #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_bank (
            .clk   (clk),
            .we    (we),
            .waddr (addr),
            .wdata (wd),
            .raddr (addr),
            .rdata (bank_rd[g])
        );
    end

    // Serial read response tracking (locked reads still answer).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_rvalid <= 1'b0;
            rd_lock_q  <= 1'b0;
            rd_sel_q   <= '0;
        end else begin
            ser_rvalid <= ser_act && ser_rd && !ser_wr;
            rd_lock_q  <= ser_locked;
            rd_sel_q   <= ser_buf_q;
        end
    end

    // Bulk drain response tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bulk_rvalid <= 1'b0;
            bulk_rsel_q <= '0;
        end else begin
            bulk_rvalid <= bulk_busy && (bulk_dir_q == BULK_DRAIN);
            bulk_rsel_q <= bulk_sel_q;
        end
    end

    // Output data selection.
    always_comb begin
        ser_rdata  = rd_lock_q ? {DW{1'b1}} : bank_rd[rd_sel_q];
        bulk_rdata = bank_rd[bulk_rsel_q];
    end
endmodule

// File: rtl/dpb_checker.sv
// Protocol checks for dual_page_buffer, attached by bind.
// Uses the session-open and lock-of-session-buffer signals from the top.
module dpb_checker #(
    parameter int DEPTH = 264,
    parameter int DW    = 8,
    parameter int AW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ser_rd,
    input logic          ser_wr,
    input logic          ser_rvalid,
    input logic [DW-1:0] ser_rdata,
    input logic          sess_act,
    input logic          sess_lock,
    input logic          bulk_busy,
    input logic [AW-1:0] bulk_idx,
    input logic          bulk_rvalid
);
    logic [15:0] run_len;

    // Length of the current bulk run in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else
            run_len <= bulk_busy ? run_len + 1'b1 : '0;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!ser_rvalid && !bulk_busy && !bulk_rvalid)); // R1

    AST_LOCKED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (sess_act && sess_lock && ser_rd && !ser_wr) |=> (ser_rvalid && ser_rdata == {DW{1'b1}})); // R7

    AST_RVALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_rvalid |-> $past(ser_rd && sess_act)); // R6

    AST_BULK_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_busy |-> (bulk_idx < AW'(DEPTH))); // R9

    AST_BULK_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_busy && $past(bulk_busy)) |-> (bulk_idx == AW'($past(bulk_idx) + 1'b1))); // R9

    AST_BULK_FIRST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bulk_busy) |-> (bulk_idx == '0)); // R10

    AST_BULK_RVALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_rvalid |-> $past(bulk_busy)); // R9

    AST_BULK_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bulk_busy) |-> (run_len == 16'(DEPTH))); // R11

    AST_BULK_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_busy |-> (run_len < 16'(DEPTH))); // R9
endmodule

bind dual_page_buffer dpb_checker #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_dpb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_rd      (ser_rd),
    .ser_wr      (ser_wr),
    .ser_rvalid  (ser_rvalid),
    .ser_rdata   (ser_rdata),
    .sess_act    (ser_act),
    .sess_lock   (ser_locked),
    .bulk_busy   (bulk_busy),
    .bulk_idx    (bulk_idx),
    .bulk_rvalid (bulk_rvalid)
);

// File: tb/dual_page_buffer_bench.sv
`timescale 1ns/1ps
module dual_page_buffer_bench;
    localparam int DEPTH = 264;
    localparam int DW    = 8;
    localparam int AW    = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    lock = '0;
    logic          ser_start = 0, ser_end = 0, ser_wr = 0, ser_rd = 0;
    logic [0:0]    ser_sel = '0;
    logic [AW-1:0] ser_offset = '0;
    logic [DW-1:0] ser_wdata = '0;
    logic [DW-1:0] ser_rdata;
    logic          ser_rvalid;
    logic          bulk_start = 0, bulk_write = 0;
    logic [0:0]    bulk_sel = '0;
    logic [DW-1:0] bulk_wdata = '0;
    logic          bulk_busy;
    logic [AW-1:0] bulk_idx;
    logic [DW-1:0] bulk_rdata;
    logic          bulk_rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] model [2][DEPTH];
    int  m_ptr = 0;
    int  m_sel = 0;
    bit  m_act = 0;

    logic [7:0] s_exp_q [$];
    string      s_tag_q [$];
    logic [7:0] b_exp_q [$];
    string      b_tag_q [$];

    always #2.5 clk = ~clk;

    dual_page_buffer u_dual_page_buffer (
        .clk(clk), .rst_n(rst_n), .lock(lock),
        .ser_start(ser_start), .ser_sel(ser_sel), .ser_offset(ser_offset),
        .ser_end(ser_end), .ser_wr(ser_wr), .ser_wdata(ser_wdata),
        .ser_rd(ser_rd), .ser_rdata(ser_rdata), .ser_rvalid(ser_rvalid),
        .bulk_start(bulk_start), .bulk_sel(bulk_sel), .bulk_write(bulk_write),
        .bulk_wdata(bulk_wdata), .bulk_busy(bulk_busy), .bulk_idx(bulk_idx),
        .bulk_rdata(bulk_rdata), .bulk_rvalid(bulk_rvalid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] pat(input int sel, input int i);
        return sel != 0 ? 8'((i * 13 + 1) & 255) : 8'((i * 7 + 3) & 255);
    endfunction

    task automatic ser_open(input int sel, input int off);
        ser_start = 1; ser_sel = 1'(sel); ser_offset = AW'(off);
        tick();
        ser_start = 0;
        m_act = 1; m_sel = sel; m_ptr = (off >= DEPTH) ? off - DEPTH : off;
    endtask

    task automatic ser_close();
        ser_end = 1;
        tick();
        ser_end = 0;
        m_act = 0;
    endtask

    task automatic ser_write(input logic [7:0] b);
        ser_wr = 1; ser_wdata = b;
        if (m_act && !lock[m_sel]) begin
            model[m_sel][m_ptr] = b;
            m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
        end
        tick();
        ser_wr = 0;
    endtask

    task automatic ser_read(input string tag);
        ser_rd = 1;
        if (m_act) begin
            if (lock[m_sel]) begin
                s_exp_q.push_back(8'hFF);
            end else begin
                s_exp_q.push_back(model[m_sel][m_ptr]);
                m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
            end
            s_tag_q.push_back(tag);
        end
        tick();
        ser_rd = 0;
    endtask

    // Bulk run; mid >= 0 pulses a competing start at that cycle.
    task automatic bulk_run(input int sel, input bit wr, input int mid, input string tag);
        int n = 0;
        if (!wr)
            for (int i = 0; i < DEPTH; i++) begin
                b_exp_q.push_back(model[sel][i]);
                b_tag_q.push_back(tag);
            end
        bulk_start = 1; bulk_sel = 1'(sel); bulk_write = wr;
        tick();
        bulk_start = 0;
        for (int i = 0; i < DEPTH + 4; i++) begin
            if (bulk_busy) begin
                bulk_wdata = pat(sel, n);
                if (wr) model[sel][n] = pat(sel, n);
                if (n == mid) begin
                    bulk_start = 1; bulk_sel = 1'(1 - sel); bulk_write = 1'b1;
                end
                tick();
                bulk_start = 0; bulk_sel = 1'(sel); bulk_write = wr;
                n++;
            end
        end
        check(n == DEPTH, {tag, " busy length"}, n, DEPTH);
        tick(); tick();
        check(!bulk_busy, {tag, " idle after run"}, int'(bulk_busy), 0);
    endtask

    // Serial monitor.
    always @(negedge clk) begin
        if (rst_n && ser_rvalid) begin
            if (s_exp_q.size() == 0) begin
                check(0, "R6 unexpected ser_rvalid", int'(ser_rdata), 0);
            end else begin
                automatic logic [7:0] e = s_exp_q.pop_front();
                automatic string t = s_tag_q.pop_front();
                check(ser_rdata === e, t, int'(ser_rdata), int'(e));
            end
        end
    end

    // Bulk monitor.
    always @(negedge clk) begin
        if (rst_n && bulk_rvalid) begin
            if (b_exp_q.size() == 0) begin
                check(0, "R9 unexpected bulk_rvalid", int'(bulk_rdata), 0);
            end else begin
                automatic logic [7:0] e = b_exp_q.pop_front();
                automatic string t = b_tag_q.pop_front();
                check(bulk_rdata === e, t, int'(bulk_rdata), int'(e));
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        check(!ser_rvalid && !bulk_busy && !bulk_rvalid, "R1 reset outputs",
              int'({ser_rvalid, bulk_busy, bulk_rvalid}), 0);
        rst_n = 1;
        tick();

        // R10: fill both buffers through the bulk port, then spot-read serially.
        bulk_run(0, 1'b1, -1, "R10 fill buf0");
        bulk_run(1, 1'b1, -1, "R10 fill buf1");
        ser_open(0, 0); ser_read("R10 buf0 byte0"); ser_read("R10 buf0 byte1"); ser_close();
        ser_open(1, 100); ser_read("R10 buf1 byte100"); ser_close();

        // R2 / R3: write a run then read it back.
        ser_open(0, 10);
        for (int i = 0; i < 4; i++) ser_write(8'hA0 + 8'(i));
        ser_close();
        ser_open(0, 10);
        for (int i = 0; i < 4; i++) ser_read("R2 R3 sequential read");
        ser_close();

        // R12: buffer 1 at the same offsets is untouched.
        ser_open(1, 10);
        for (int i = 0; i < 4; i++) ser_read("R12 other buffer intact");
        ser_close();

        // R4: wrap across the end of buffer 1.
        ser_open(1, 262);
        for (int i = 0; i < 4; i++) ser_write(8'hC0 + 8'(i));
        ser_close();
        ser_open(1, 0); ser_read("R4 wrapped write at 0"); ser_read("R4 wrapped write at 1"); ser_close();
        ser_open(1, 262);
        for (int i = 0; i < 4; i++) ser_read("R4 read wraps");
        ser_close();

        // R5: out-of-range start offset folds.
        ser_open(0, 300); ser_write(8'h55); ser_close();
        ser_open(0, 36); ser_read("R5 offset 300 hit byte 36"); ser_close();

        // R6: strobes with no session are ignored.
        ser_wdata = 8'h99; ser_wr = 1; tick(); ser_wr = 0;
        ser_rd = 1; tick(); ser_rd = 0;
        tick();
        check(!ser_rvalid, "R6 no rvalid outside session", int'(ser_rvalid), 0);
        ser_open(0, 36); ser_read("R6 byte 36 unchanged"); ser_close();

        // R7: locked buffer drops writes, reads ones, pointer holds.
        lock = 2'b01;
        ser_open(0, 10);
        ser_write(8'h11);
        ser_read("R7 locked read ones");
        lock = 2'b00;
        ser_read("R7 pointer held and write dropped");
        ser_close();

        // R8: buffer 1 works while buffer 0 is locked.
        lock = 2'b01;
        ser_open(1, 5); ser_write(8'h3C); ser_close();
        ser_open(1, 5); ser_read("R8 unlocked buffer usable"); ser_close();
        lock = 2'b00;

        // R9: stream out buffer 0 in order.
        bulk_run(0, 1'b0, -1, "R9 drain buf0");

        // R11: competing start mid-run is ignored; buffer 0 must stay intact.
        bulk_run(1, 1'b0, 100, "R11 drain buf1 with competing start");
        ser_open(0, 36); ser_read("R11 buf0 not refilled"); ser_close();

        repeat (4) tick();
        check(s_exp_q.size() == 0, "R2 serial results all delivered", s_exp_q.size(), 0);
        check(b_exp_q.size() == 0, "R9 bulk results all delivered", b_exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule